// File: doc/BRIEF.md
# Masked Sticky Interrupt Aggregator

This block gathers the interrupt sources of a communication controller into one level interrupt line. Five single-cycle event pulses and one level source feed a status register. The pulses are a frame received, a frame transmitted, a receive overrun, the receive buffer becoming full, and a change of transmit buffer state. The level source is "receive buffer holds frames". A status bit is latched only while its mask bit is clear. An event that arrives while masked is dropped for good. It does not wait for the mask to be lifted.

Software uses a small word-addressed register port. It clears status bits by writing ones. It changes the enable and mask registers through separate set and clear addresses, so it never needs a read-modify-write. The interrupt line is high whenever a latched status bit is also enabled. The receive-not-empty bit is raised again in every cycle in which the stored-frame count is nonzero and the bit is unmasked. While frames remain, clearing that bit has no lasting effect.

Top module: `irq_aggregator`

## Requirements
- R1: An event sets its status bit at the next clock edge only if its mask bit is 0. An event that arrives while masked is discarded, and clearing the mask afterwards does not make the bit appear.
- R2: A write to address 0 (status) clears every status bit written as 1 and leaves the other bits unchanged. A read of address 0 returns the status.
- R3: A write to address 1 ORs the written bits into the enable register. A write to address 2 clears the written bits of the enable register.
- R4: A write to address 3 ORs the written bits into the mask register. A write to address 4 clears the written bits of the mask register.
- R5: A read of address 1 or 2 returns the enable register, and a read of address 3 or 4 returns the mask register. Addresses 5 to 7 read as zero, and register bits above bit 5 always read as zero.
- R6: `irq` is high exactly when the bitwise AND of status and enable is nonzero. It reflects a register write from the clock edge that performs the write.
- R7: While `rx_frames` is nonzero and mask bit 5 is clear, status bit 5 is set again at every clock edge, so a write-one-to-clear of that bit has no lasting effect.
- R8: While `rst_n` is low, status, enable and mask are all zero and `irq` is low.
- R9: If an unmasked event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R10: Status bit positions are fixed: receive 0, transmit 1, overrun 2, buffer full 3, transmit buffer change 4, buffer not empty 5. The enable and mask registers use the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| ev_rx_done | input | 1 | Frame received pulse |
| ev_tx_done | input | 1 | Frame transmitted pulse |
| ev_rx_overrun | input | 1 | Receive overrun pulse |
| ev_rx_full | input | 1 | Receive buffer full pulse |
| ev_txbuf_change | input | 1 | Transmit buffer state change pulse |
| rx_frames | input | CNT_W | Stored-frame count (level source) |
| irq | output | 1 | Level interrupt output |

## Verification
The bench builds the block with `CNT_W` set to 3, which keeps the frame-count source small. It uses the default 32-bit data width and 3-bit address, so the whole address space can be read, including the unmapped words. With only six status bits, the bench can sweep all 64 status patterns against all 64 enable patterns and check the interrupt line each time. It also tries every source both masked and unmasked. The tight cases are run on purpose: a clear and an event landing together, and a clear of the receive-not-empty bit while frames remain.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_rx_done,
  input  logic              ev_tx_done,
  input  logic              ev_rx_overrun,
  input  logic              ev_rx_full,
  input  logic              ev_txbuf_change,
  input  logic [CNT_W-1:0]  rx_frames,
  output logic              irq
);
  localparam int NSRC = 6;
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MKSET = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_MKCLR = ADDR_W'(4);

  logic [NSRC-1:0] status_q, enable_q, mask_q;
  logic [NSRC-1:0] src, wbits;
  logic hit_stat, hit_ens, hit_enc, hit_mks, hit_mkc;

  // R10: fixed source positions
  assign src   = {|rx_frames, ev_txbuf_change, ev_rx_full,
                  ev_rx_overrun, ev_tx_done, ev_rx_done};
  assign wbits = bus_wdata[NSRC-1:0];

  assign hit_stat = bus_wr && (bus_addr == A_STAT);
  assign hit_ens  = bus_wr && (bus_addr == A_ENSET);
  assign hit_enc  = bus_wr && (bus_addr == A_ENCLR);
  assign hit_mks  = bus_wr && (bus_addr == A_MKSET);
  assign hit_mkc  = bus_wr && (bus_addr == A_MKCLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= (status_q & ~(hit_stat ? wbits : '0)) | (src & ~mask_q);
      if (hit_ens)      enable_q <= enable_q | wbits;
      else if (hit_enc) enable_q <= enable_q & ~wbits;
      if (hit_mks)      mask_q <= mask_q | wbits;
      else if (hit_mkc) mask_q <= mask_q & ~wbits;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STAT:           bus_rdata = DATA_W'(status_q);
      A_ENSET, A_ENCLR: bus_rdata = DATA_W'(enable_q);
      A_MKSET, A_MKCLR: bus_rdata = DATA_W'(mask_q);
      default:          bus_rdata = '0;
    endcase
  end

  assign irq = |(status_q & enable_q);

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    assert_masked_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q[i] && !status_q[i]) |=> !status_q[i]);
    assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_stat && wbits[i] && !src[i]) |=> !status_q[i]);
    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (src[i] && !mask_q[i]) |=> status_q[i]);
  end

  assert_enable_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ens |=> ((enable_q & $past(wbits)) == $past(wbits)));
  assert_mask_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mkc |=> ((mask_q & $past(wbits)) == '0));
  assert_irq_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_enc && (&wbits)) |=> !irq);
  assert_rxne_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_frames != '0) && !mask_q[5]) |=> bus_rdata[5] || (bus_addr != A_STAT));
endmodule

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;
  localparam int DW = 32, AW = 3, CW = 3;
  logic clk = 0, rst_n = 0, bus_wr = 0, irq;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic [4:0] ev = '0;
  logic [CW-1:0] rx_frames = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_aggregator #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_rx_done(ev[0]), .ev_tx_done(ev[1]), .ev_rx_overrun(ev[2]),
    .ev_rx_full(ev[3]), .ev_txbuf_change(ev[4]),
    .rx_frames(rx_frames), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic pulse(input logic [4:0] v);
    @(negedge clk); ev = v;
    @(negedge clk); ev = '0;
  endtask

  task automatic wr_pulse(input logic [AW-1:0] a, input logic [31:0] d, input logic [4:0] v);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d; ev = v;
    @(negedge clk); bus_wr = 0; bus_wdata = '0; ev = '0;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R8: reset state
    for (int a = 0; a < 5; a++) begin
      rd(AW'(a), v); chk("R8 reset reg", v, 0);
    end
    chk("R8 reset irq", {31'b0, irq}, 0);
    rst_n = 1;

    // R1 / R10: each source, masked and unmasked
    for (int i = 0; i < 5; i++) begin
      for (int m = 0; m < 2; m++) begin
        wr(4, 32'hFFFF_FFFF);
        wr(0, 32'hFFFF_FFFF);
        if (m == 1) wr(3, 32'h1 << i);
        pulse(5'(1 << i));
        rd(0, v); chk("R10 R1 event latch", v, (m == 1) ? 0 : (32'h1 << i));
        wr(4, 32'hFFFF_FFFF);
        rd(0, v); chk("R1 masked event not held", v, (m == 1) ? 0 : (32'h1 << i));
      end
    end

    // R7: level source bit 5
    wr(0, 32'hFFFF_FFFF);
    @(negedge clk); rx_frames = 3;
    rd(0, v); chk("R7 rxne set", v, 32'h20);
    wr(0, 32'h20);
    rd(0, v); chk("R7 rxne clear ignored", v, 32'h20);
    wr(3, 32'h20);
    wr(0, 32'h20);
    rd(0, v); chk("R7 rxne masked cleared", v, 0);
    @(negedge clk); rx_frames = 0;
    wr(4, 32'h20);
    rd(0, v); chk("R7 rxne gone", v, 0);

    // R2: partial write-one-to-clear
    pulse(5'h1F);
    wr(0, 32'h05);
    rd(0, v); chk("R2 w1c partial", v, 32'h1A);
    wr(0, 32'hFFFF_FFFF);

    // R3 R4 R5: set/clear addresses and readback
    wr(1, 32'h2C); rd(1, v); chk("R3 R5 enset read", v, 32'h2C);
    rd(2, v); chk("R5 enclr read", v, 32'h2C);
    wr(1, 32'h01); rd(1, v); chk("R3 enset or", v, 32'h2D);
    wr(2, 32'h0C); rd(2, v); chk("R3 enclr", v, 32'h21);
    wr(1, 32'hFFFF_FFFF); rd(1, v); chk("R5 upper bits zero", v, 32'h3F);
    wr(2, 32'hFFFF_FFFF);
    wr(3, 32'h12); rd(3, v); chk("R4 R5 mkset read", v, 32'h12);
    rd(4, v); chk("R5 mkclr read", v, 32'h12);
    wr(4, 32'h02); rd(3, v); chk("R4 mkclr", v, 32'h10);
    wr(4, 32'hFFFF_FFFF);
    for (int a = 5; a < 8; a++) begin
      rd(AW'(a), v); chk("R5 unmapped", v, 0);
    end

    // R6: all status patterns against all enable patterns
    for (int s = 0; s < 64; s++) begin
      wr(0, 32'hFFFF_FFFF);
      pulse(5'(s));
      if (s[5]) begin
        @(negedge clk); rx_frames = 1;
        @(negedge clk); rx_frames = 0;
      end
      rd(0, v); chk("R6 status setup", v, 32'(s));
      for (int e = 0; e < 64; e++) begin
        wr(2, 32'h3F);
        wr(1, 32'(e));
        chk("R6 irq", {31'b0, irq}, {31'b0, |(s & e)});
      end
    end
    wr(2, 32'h3F);

    // R9: event and clear together
    wr(0, 32'hFFFF_FFFF);
    wr_pulse(0, 32'hFFFF_FFFF, 5'h02);
    rd(0, v); chk("R9 event wins", v, 32'h02);
    wr(3, 32'h02);
    wr_pulse(0, 32'hFFFF_FFFF, 5'h02);
    rd(0, v); chk("R9 masked event with clear", v, 0);

    // R8: reset mid-run
    wr(4, 32'hFFFF_FFFF);
    pulse(5'h1F); wr(1, 32'h3F); wr(3, 32'h20);
    chk("R8 irq before reset", {31'b0, irq}, 1);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R8 irq in reset", {31'b0, irq}, 0);
    for (int a = 0; a < 5; a++) begin
      rd(AW'(a), v); chk("R8 regs in reset", v, 0);
    end
    rst_n = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule